// File: doc/BRIEF.md
# Dual-Channel Blink and Dimming Generator with Per-Pin Mode Select

The block produces two independent blink/dimming waveforms, called channel 0 and channel 1. Each waveform comes from an 8-bit duty counter that advances once every `PSC+1` pulses of a base tick strobe. The channel is active while that counter is below the channel's 8-bit duty value. When the tick runs at 256 × 152 Hz, a period lasts `(PSC+1)/152` seconds and the duty fraction is `PWM/256`.

Sixteen outputs each take a 2-bit mode code from a 32-bit selector bank. The code sets the pin released, pulled low, following channel 0 or following channel 1. An asserted output bit means the open-drain pad is pulled low, so the LED is lit. Software writes the prescaler and duty values. It pulses a per-channel write strobe whenever it stores a new duty value, and that strobe restarts the channel.

Top module: `dual_blink_led`

## Requirements
- R1: With the tick high on every clock, a channel's duty counter advances once every `PSC+1` ticks, so one full 256-step period spans `256*(PSC+1)` ticks.
- R2: A channel's prescaler and duty counter hold their values on any clock where the tick input is low and no duty write is strobed.
- R3: A duty write strobe on a channel resets that channel's duty counter and prescaler to 0 on the next clock and loads the current prescaler input as the active period.
- R4: A channel is active exactly while its duty counter is below its duty input: a duty of 0 never activates it, and 255 activates it on 255 of 256 steps.
- R5: A prescaler input change without a duty write takes effect only when the duty counter wraps from 255 to 0, so the period in progress keeps its old length.
- R6: Pin n takes its mode from `sel_bank[2n+1:2n]` (byte g covers pins 4g to 4g+3). Code 00 releases the pin (output 0), 01 pulls it low (output 1), 10 follows channel 0 and 11 follows channel 1.
- R7: Outputs are registered: each output reflects the selector codes and channel states present one clock earlier.
- R8: A synchronous active-high reset clears all outputs, both duty counters, both prescalers and both active periods to 0.
- R9: The two channels are independent: a write or setting on one channel has no effect on the other channel's waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base tick strobe, one clock wide per pulse |
| psc0 | input | 8 | Channel 0 prescaler value |
| pwm0 | input | 8 | Channel 0 duty value |
| pwm0_wr | input | 1 | Channel 0 duty write strobe (restarts channel 0) |
| psc1 | input | 8 | Channel 1 prescaler value |
| pwm1 | input | 8 | Channel 1 duty value |
| pwm1_wr | input | 1 | Channel 1 duty write strobe (restarts channel 1) |
| sel_bank | input | 32 | Per-pin 2-bit mode codes, pin n at bits [2n+1:2n] |
| pull_low | output | 16 | Per-pin pull-low enable, 1 means the LED is lit |

## Verification
The assertions assume two things about the inputs: the tick is a single-clock strobe sampled on the clock, and the write strobes are single-cycle pulses that the counters see synchronously. The per-pin assertions also assume that mode codes and channel states only matter at clock edges. The stimulus therefore changes every input on the falling edge, holds it stable across the rising edge and releases each write strobe after exactly one edge. Tick patterns are continuous, every other cycle or every third cycle, which keeps them within the strobe assumption. Prescaler changes arrive both together with a write and alone in mid-period, so both load paths are exercised.

// File: rtl/dual_blink_pkg.sv
package dual_blink_pkg;

    localparam int PSC_W  = 8;
    localparam int DUTY_W = 8;
    localparam int NCHAN  = 2;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        PIN_RELEASE = 2'b00,
        PIN_LOW     = 2'b01,
        PIN_CHAN0   = 2'b10,
        PIN_CHAN1   = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic [PSC_W-1:0]  psc;
        logic [DUTY_W-1:0] duty;
        logic              restart;
    } chan_cfg_t;

    function automatic logic pin_drive(pin_mode_e mode, logic [NCHAN-1:0] active);
        case (mode)
            PIN_RELEASE: return 1'b0;
            PIN_LOW:     return 1'b1;
            PIN_CHAN0:   return active[0];
            default:     return active[1];
        endcase
    endfunction

endpackage

// File: rtl/blink_chan.sv
module blink_chan
    import dual_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  chan_cfg_t         cfg,
    output logic              active,
    output logic [DUTY_W-1:0] duty_cnt
);
    logic [PSC_W-1:0]  pre_q;
    logic [PSC_W-1:0]  psc_act_q;
    logic [DUTY_W-1:0] duty_q;
    logic              step;
    logic              wrap;

    assign step = tick && (pre_q == psc_act_q);
    assign wrap = step && (duty_q == {DUTY_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q     <= '0;
            psc_act_q <= '0;
            duty_q    <= '0;
        end else if (cfg.restart) begin
            pre_q     <= '0;
            duty_q    <= '0;
            psc_act_q <= cfg.psc;
        end else if (tick) begin
            if (step) begin
                pre_q  <= '0;
                duty_q <= duty_q + 1'b1;
                if (wrap) psc_act_q <= cfg.psc;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign active   = (duty_q < cfg.duty);
    assign duty_cnt = duty_q;
endmodule

// File: rtl/pin_router.sv
module pin_router
    import dual_blink_pkg::*;
#(
    parameter int NPINS = 16,
    localparam int SEL_W = MODE_W * NPINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_bank,
    input  logic [NCHAN-1:0] chan_active,
    output logic [NPINS-1:0] pull_low
);
    logic [NPINS-1:0] drive_nxt;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign drive_nxt[i] = pin_drive(pin_mode_e'(sel_bank[MODE_W*i +: MODE_W]), chan_active);
    end

    always_ff @(posedge clk) begin
        if (rst) pull_low <= '0;
        else     pull_low <= drive_nxt;
    end
endmodule

// File: rtl/dual_blink_led.sv
module dual_blink_led
    import dual_blink_pkg::*;
#(
    parameter int NPINS = 16,
    localparam int SEL_W = MODE_W * NPINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [PSC_W-1:0]  psc0,
    input  logic [DUTY_W-1:0] pwm0,
    input  logic              pwm0_wr,
    input  logic [PSC_W-1:0]  psc1,
    input  logic [DUTY_W-1:0] pwm1,
    input  logic              pwm1_wr,
    input  logic [SEL_W-1:0]  sel_bank,
    output logic [NPINS-1:0]  pull_low
);
    chan_cfg_t         cfg_v  [NCHAN];
    logic [NCHAN-1:0]  chan_on;
    logic [DUTY_W-1:0] duty_v [NCHAN];
    logic [NCHAN-1:0]  restart_v;

    assign cfg_v[0]  = '{psc: psc0, duty: pwm0, restart: pwm0_wr};
    assign cfg_v[1]  = '{psc: psc1, duty: pwm1, restart: pwm1_wr};
    assign restart_v = {pwm1_wr, pwm0_wr};

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        blink_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .cfg      (cfg_v[c]),
            .active   (chan_on[c]),
            .duty_cnt (duty_v[c])
        );
    end

    pin_router #(.NPINS(NPINS)) u_route (
        .clk         (clk),
        .rst         (rst),
        .sel_bank    (sel_bank),
        .chan_active (chan_on),
        .pull_low    (pull_low)
    );
endmodule

// File: rtl/dual_blink_chk.sv
module dual_blink_chk
    import dual_blink_pkg::*;
#(
    parameter int NPINS = 16,
    localparam int SEL_W = MODE_W * NPINS
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [NCHAN-1:0]  restart,
    input logic [NCHAN-1:0]  chan_on,
    input logic [DUTY_W-1:0] duty0,
    input logic [DUTY_W-1:0] duty1,
    input logic [SEL_W-1:0]  sel_bank,
    input logic [NPINS-1:0]  pull_low
);
    // R8
    reset_clear_chk: assert property (@(posedge clk) rst |=> (pull_low == '0));

    // R3
    restart0_chk: assert property (@(posedge clk) disable iff (rst)
        restart[0] |=> (duty0 == '0));

    // R3
    restart1_chk: assert property (@(posedge clk) disable iff (rst)
        restart[1] |=> (duty1 == '0));

    // R2
    hold0_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart[0]) |=> $stable(duty0));

    // R2
    hold1_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart[1]) |=> $stable(duty1));

    for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
        // R6
        released_chk: assert property (@(posedge clk) disable iff (rst)
            (sel_bank[MODE_W*i +: MODE_W] == 2'b00) |=> !pull_low[i]);
        // R6
        forced_chk: assert property (@(posedge clk) disable iff (rst)
            (sel_bank[MODE_W*i +: MODE_W] == 2'b01) |=> pull_low[i]);
        // R7
        follow0_chk: assert property (@(posedge clk) disable iff (rst)
            (sel_bank[MODE_W*i +: MODE_W] == 2'b10) |=> (pull_low[i] == $past(chan_on[0])));
        // R7
        follow1_chk: assert property (@(posedge clk) disable iff (rst)
            (sel_bank[MODE_W*i +: MODE_W] == 2'b11) |=> (pull_low[i] == $past(chan_on[1])));
    end
endmodule

bind dual_blink_led dual_blink_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .restart  (restart_v),
    .chan_on  (chan_on),
    .duty0    (duty_v[0]),
    .duty1    (duty_v[1]),
    .sel_bank (sel_bank),
    .pull_low (pull_low)
);

// File: tb/dual_blink_led_test.sv
`timescale 1ns/1ps
module dual_blink_led_test;
    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [7:0]  psc0 = '0, pwm0 = '0, psc1 = '0, pwm1 = '0;
    logic        pwm0_wr = 1'b0, pwm1_wr = 1'b0;
    logic [31:0] sel_bank = '0;
    logic [15:0] pull_low;

    int checks = 0;
    int errors = 0;
    int tc [2];
    int pa [2];
    int tmode = 0;
    int ccount = 0;
    string req = "R1";

    always #2.5 clk = ~clk;

    dual_blink_led #(.NPINS(NP)) uut (
        .clk(clk), .rst(rst), .tick(tick),
        .psc0(psc0), .pwm0(pwm0), .pwm0_wr(pwm0_wr),
        .psc1(psc1), .pwm1(pwm1), .pwm1_wr(pwm1_wr),
        .sel_bank(sel_bank), .pull_low(pull_low)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit chan_on(input int t, input int p, input logic [7:0] duty);
        return ((t / (p + 1)) % 256) < int'(duty);
    endfunction

    // Model of one channel over one clock edge, from R1, R2, R3, R5.
    task automatic adv(input int c, input bit wr, input bit tk, input logic [7:0] ps);
        if (wr) begin
            tc[c] = 0;
            pa[c] = int'(ps);
        end else if (tk) begin
            tc[c]++;
            if (tc[c] == 256 * (pa[c] + 1)) begin
                tc[c] = 0;
                pa[c] = int'(ps);
            end
        end
    endtask

    // One clock: expected output from pre-edge inputs and model state (R6, R7).
    task automatic cyc();
        logic [15:0] e;
        bit b0, b1, w0, w1, tk;
        logic [7:0] s0, s1;
        tick = (tmode == 0) || ((ccount % (tmode + 1)) == 0);
        b0 = chan_on(tc[0], pa[0], pwm0);
        b1 = chan_on(tc[1], pa[1], pwm1);
        for (int i = 0; i < NP; i++) begin
            case (sel_bank[2*i +: 2])
                2'b00: e[i] = 1'b0;
                2'b01: e[i] = 1'b1;
                2'b10: e[i] = b0;
                default: e[i] = b1;
            endcase
        end
        w0 = pwm0_wr; w1 = pwm1_wr; tk = tick; s0 = psc0; s1 = psc1;
        @(posedge clk);
        adv(0, w0, tk, s0);
        adv(1, w1, tk, s1);
        ccount++;
        #1;
        chk(pull_low === e, req, pull_low, e);
        @(negedge clk);
        pwm0_wr = 1'b0;
        pwm1_wr = 1'b0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R8: reset holds outputs clear even with all pins forced on
        sel_bank = {16{2'b01}};
        tick = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            chk(pull_low == '0, "R8", pull_low, 16'h0);
        end
        @(negedge clk);
        rst = 1'b0;
        tc[0] = 0; tc[1] = 0; pa[0] = 0; pa[1] = 0;
        req = "R8";
        run(3);

        // R1, R4, R6, R9: sweep prescaler and duty on both channels
        sel_bank = 32'h1B1B_E4E4;
        foreach (pa[c]) begin end
        for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 5; v++) begin
                logic [7:0] dv;
                case (v)
                    0: dv = 8'd0;
                    1: dv = 8'd1;
                    2: dv = 8'd77;
                    3: dv = 8'd128;
                    default: dv = 8'd255;
                endcase
                req = (v == 0 || v == 4) ? "R4" : "R1";
                psc0 = 8'(p); pwm0 = dv;
                psc1 = 8'(2 - p); pwm1 = ~dv;
                pwm0_wr = 1'b1; pwm1_wr = 1'b1;
                run(256 * (p + 1) + 24);
            end
        end

        // R2: gated tick, every other and every third cycle
        req = "R2";
        tmode = 1;
        psc0 = 8'd1; pwm0 = 8'd100; pwm0_wr = 1'b1;
        run(1100);
        tmode = 2;
        psc1 = 8'd0; pwm1 = 8'd200; pwm1_wr = 1'b1;
        run(800);
        tmode = 0;

        // R5: prescaler change mid-period without a duty write
        req = "R5";
        psc0 = 8'd1; pwm0 = 8'd128; pwm0_wr = 1'b1;
        run(200);
        psc0 = 8'd3;
        run(512 + 1024 + 40);

        // R3: duty write mid-period restarts only channel 0 (R9 for channel 1)
        req = "R3";
        psc1 = 8'd1; pwm1 = 8'd64; pwm1_wr = 1'b1;
        run(300);
        pwm0 = 8'd10; pwm0_wr = 1'b1;
        run(60);
        req = "R9";
        pwm0 = 8'd250; pwm0_wr = 1'b1;
        run(300);

        // R6, R7: selector changes every clock through all codes
        req = "R7";
        for (int k = 0; k < 96; k++) begin
            sel_bank = 32'h9E37_79B9 * (k + 1);
            cyc();
        end
        req = "R6";
        sel_bank = 32'hFFFF_0000;
        run(20);
        sel_bank = 32'h0000_AAAA;
        run(20);

        // R8: reset in mid-run clears outputs
        sel_bank = {16{2'b01}};
        rst = 1'b1;
        @(posedge clk); #1;
        chk(pull_low == '0, "R8", pull_low, 16'h0);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule